// File: doc/BRIEF.md
# Front-End Power-Up Configuration Sequencer

This block brings an external analog front-end out of power-up by writing a fixed series of seven 16-bit command words over a three-wire serial write port. The port has a serial clock, serial data and an active-low chip select. A single start pulse launches the series. The block then holds off until the surrounding timing generator reports that the blanking, sampling-clock, sampling-signal and optical-black timing inputs are stable. After that it writes the words in a fixed order.

The first two words drive the device's soft reset low and then release it. Two configuration words follow. Then comes an offset-reset handshake: the offset-reset bit is written high, and later written low. Each of these two phases is separated from the word before it by a minimum number of vertical-sync periods. A final data word closes the series. The user-selectable fields of the words come from configuration inputs, which are latched when the start pulse is accepted. If vertical sync stops arriving during a wait, the series is abandoned and a timeout flag is raised.

Top module: `fe_init_seq`

## Requirements
- R1: During and directly after synchronous reset, chip select is high, serial clock and data are low, busy, done and the timeout flag are low, and the step index is 0.
- R2: Each write holds chip select low for exactly 16 serial-clock rising edges. Data is sent most significant bit first. It changes only together with a falling serial-clock edge or the falling chip select, and it holds steady while the serial clock is high. The serial clock stays low whenever chip select is high.
- R3: With A = cfg_main_i, B = cfg_aux_i and C = cfg_data_i, the words are sent in this order:
  - 0x0001 (bit 13 = 0, soft reset low)
  - 0x2001 (bit 13 = 1, soft reset released)
  - {6'b001000, A, 2'b01}
  - {9'b111010000, B, 2'b10}
  - {6'b011000, A, 2'b01} (bit 14 set: offset reset high)
  - {6'b001000, A, 2'b01} (offset reset cleared)
  - {1'b0, C, 2'b00}
- R4: After an accepted start, no write begins while timing_ok_i is low. Busy is already high during that hold-off.
- R5: At least WAIT_ONE rising vsync_i edges occur between the end of step 3 and the start of step 4. At least WAIT_FOUR edges occur between the end of step 4 and the start of step 5.
- R6: Chip select stays high for at least CS_GAP serial-clock periods (2·CLK_DIV·CS_GAP clock cycles) between consecutive writes. The other steps need no vertical-sync wait.
- R7: busy_o rises one cycle after start_i is sampled in idle. It falls in the same cycle as done_o, which is high for exactly one cycle after the last word's chip-select gap.
- R8: A start pulse while busy is ignored: no extra words are written and there is no second done pulse.
- R9: While chip select is low, step_o equals the 0-based index (0 to 6) of the word being written.
- R10: If no vsync_i rising edge arrives within TIMEOUT_CYC cycles during a wait, vs_timeout_o goes high and busy falls without a done pulse. No further word is written. The flag clears at the next accepted start.
- R11: The configuration inputs are captured at the accepted start. Changes to them during a series do not alter the words written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| timing_ok_i | input | 1 | High when the front-end timing inputs are stable |
| vsync_i | input | 1 | Vertical-sync pulse, counted on rising edges |
| cfg_main_i | input | 8 | Selectable field of the configuration and offset-reset words |
| cfg_aux_i | input | 5 | Selectable field of the second configuration word |
| cfg_data_i | input | 13 | Selectable field of the final data word |
| sclk_o | output | 1 | Serial clock, idle low |
| sdata_o | output | 1 | Serial data, MSB first |
| cs_n_o | output | 1 | Active-low chip select |
| busy_o | output | 1 | Series in progress |
| done_o | output | 1 | One-cycle pulse when the series completes |
| step_o | output | 3 | Index of the current step |
| vs_timeout_o | output | 1 | Vertical sync missing during a wait |

## Verification
The bench builds the block with CLK_DIV = 2, CS_GAP = 2, WAIT_ONE = 1 and WAIT_FOUR = 4. It uses TIMEOUT_CYC = 2000, with vertical sync every 300 cycles. A whole series then fits in a few thousand cycles, and each wait spans real vertical-sync counts of one and four. The shortened timeout lets the abort path and the recovery after it run in the same run as the normal series. A serial decoder in the bench rebuilds every word and measures the vertical-sync edges and idle cycles between writes.

// File: rtl/fe_init_pkg.sv
package fe_init_pkg;

  localparam int unsigned WORD_W     = 16;
  localparam int unsigned STEP_W     = 3;
  localparam int unsigned STEP_W1    = 3;   // step that precedes the single-period wait
  localparam int unsigned STEP_W4    = 4;   // step that precedes the four-period wait
  localparam int unsigned STEP_FINAL = 6;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_HOLD,
    SQ_SEND,
    SQ_XFER,
    SQ_VWAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    TX_IDLE,
    TX_SHIFT,
    TX_GAP
  } tx_state_t;

  function automatic logic [WORD_W-1:0] build_word(
    input logic [STEP_W-1:0] idx,
    input logic [7:0]        fmain,
    input logic [4:0]        faux,
    input logic [12:0]       fdata
  );
    logic [WORD_W-1:0] w;
    case (idx)
      3'd0:    w = 16'h0001;
      3'd1:    w = 16'h2001;
      3'd2:    w = {6'b001000, fmain, 2'b01};
      3'd3:    w = {9'b111010000, faux, 2'b10};
      3'd4:    w = {6'b011000, fmain, 2'b01};
      3'd5:    w = {6'b001000, fmain, 2'b01};
      default: w = {1'b0, fdata, 2'b00};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fe_ser_tx.sv
module fe_ser_tx
  import fe_init_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned CS_GAP  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              sdata_o,
  output logic              cs_n_o
);

  localparam int unsigned DIV_W   = $clog2(CLK_DIV) + 1;
  localparam int unsigned GAP_CYC = CS_GAP * 2 * CLK_DIV;
  localparam int unsigned GAP_W   = $clog2(GAP_CYC) + 1;
  localparam int unsigned BIT_W   = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  tx_state_t         st;
  logic [WORD_W-1:0] sreg;
  logic [DIV_W-1:0]  div_cnt;
  logic [BIT_W-1:0]  bit_idx;
  logic [GAP_W-1:0]  gap_cnt;

  assign ready_o = (st == TX_IDLE);

  always_ff @(posedge clk) begin
    done_o <= 1'b0;
    if (rst) begin
      st      <= TX_IDLE;
      sreg    <= '0;
      div_cnt <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      case (st)
        TX_IDLE: begin
          if (load_i) begin
            sreg    <= word_i;
            sdata_o <= word_i[WORD_W-1];
            cs_n_o  <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
            st      <= TX_SHIFT;
          end
        end
        TX_SHIFT: begin
          if (div_cnt == DIV_LAST) begin
            div_cnt <= '0;
            if (!sclk_o) begin
              sclk_o <= 1'b1;
            end else begin
              sclk_o <= 1'b0;
              if (bit_idx == BIT_LAST) begin
                cs_n_o  <= 1'b1;
                sdata_o <= 1'b0;
                gap_cnt <= '0;
                st      <= TX_GAP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
                sreg    <= {sreg[WORD_W-2:0], 1'b0};
                sdata_o <= sreg[WORD_W-2];
              end
            end
          end else begin
            div_cnt <= div_cnt + 1'b1;
          end
        end
        TX_GAP: begin
          if (gap_cnt == GAP_LAST) begin
            st     <= TX_IDLE;
            done_o <= 1'b1;
          end else begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  // Count of cycles chip select has been high, saturating, for the gap check.
  logic [GAP_W:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)
      hi_run <= (GAP_W + 1)'(GAP_CYC);
    else if (cs_n_o)
      hi_run <= (hi_run >= (GAP_W + 1)'(GAP_CYC)) ? hi_run : hi_run + 1'b1;
    else
      hi_run <= '0;
  end

  a_r2_sclk_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  a_r2_data_held_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_run >= (GAP_W + 1)'(GAP_CYC)));

endmodule

// File: rtl/fe_vsync_wait.sv
module fe_vsync_wait #(
  parameter int unsigned TIMEOUT_CYC = 2000000,
  parameter int unsigned CNT_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             vsync_i,
  output logic             met_o,
  output logic             timeout_o
);

  localparam int unsigned TMO_W = $clog2(TIMEOUT_CYC) + 1;
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);

  logic             active;
  logic             vs_q;
  logic [CNT_W-1:0] edges;
  logic [CNT_W-1:0] edges_nx;
  logic [CNT_W-1:0] tgt;
  logic [TMO_W-1:0] tmo_cnt;
  logic             vs_edge;

  assign vs_edge  = vsync_i & ~vs_q;
  assign edges_nx = edges + 1'b1;

  always_ff @(posedge clk) begin
    met_o     <= 1'b0;
    timeout_o <= 1'b0;
    if (rst) begin
      active  <= 1'b0;
      vs_q    <= 1'b0;
      edges   <= '0;
      tgt     <= '0;
      tmo_cnt <= '0;
    end else begin
      vs_q <= vsync_i;
      if (arm_i) begin
        active  <= 1'b1;
        edges   <= '0;
        tgt     <= target_i;
        tmo_cnt <= '0;
      end else if (active) begin
        if (vs_edge) begin
          edges   <= edges_nx;
          tmo_cnt <= '0;
          if (edges_nx >= tgt) begin
            met_o  <= 1'b1;
            active <= 1'b0;
          end
        end else if (tmo_cnt == TMO_LAST) begin
          timeout_o <= 1'b1;
          active    <= 1'b0;
        end else begin
          tmo_cnt <= tmo_cnt + 1'b1;
        end
      end
    end
  end

  a_r10_met_or_timeout: assert property (@(posedge clk) disable iff (rst)
    !(met_o && timeout_o));

  a_r5_met_only_after_wait: assert property (@(posedge clk) disable iff (rst)
    met_o |-> $past(active));

endmodule

// File: rtl/fe_init_seq.sv
module fe_init_seq
  import fe_init_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned CS_GAP      = 2,
  parameter int unsigned WAIT_ONE    = 1,
  parameter int unsigned WAIT_FOUR   = 4,
  parameter int unsigned TIMEOUT_CYC = 2000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start_i,
  input  logic        timing_ok_i,
  input  logic        vsync_i,
  input  logic [7:0]  cfg_main_i,
  input  logic [4:0]  cfg_aux_i,
  input  logic [12:0] cfg_data_i,
  output logic        sclk_o,
  output logic        sdata_o,
  output logic        cs_n_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [2:0]  step_o,
  output logic        vs_timeout_o
);

  localparam int unsigned WAIT_MAX = (WAIT_ONE > WAIT_FOUR) ? WAIT_ONE : WAIT_FOUR;
  localparam int unsigned CNT_W    = $clog2(WAIT_MAX + 1) + 1;

  seq_state_t        st;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        fmain_q;
  logic [4:0]        faux_q;
  logic [12:0]       fdata_q;
  logic              tx_load;
  logic              tx_ready;
  logic              tx_done;
  logic              vs_arm;
  logic [CNT_W-1:0]  vs_tgt;
  logic              vs_met;
  logic              vs_tmo;
  logic [WORD_W-1:0] cur_word;

  assign cur_word = build_word(step_q, fmain_q, faux_q, fdata_q);
  assign step_o   = step_q;

  always_ff @(posedge clk) begin
    done_o  <= 1'b0;
    tx_load <= 1'b0;
    vs_arm  <= 1'b0;
    if (rst) begin
      st           <= SQ_IDLE;
      step_q       <= '0;
      fmain_q      <= '0;
      faux_q       <= '0;
      fdata_q      <= '0;
      vs_tgt       <= '0;
      busy_o       <= 1'b0;
      vs_timeout_o <= 1'b0;
    end else begin
      case (st)
        SQ_IDLE: begin
          if (start_i) begin
            fmain_q      <= cfg_main_i;
            faux_q       <= cfg_aux_i;
            fdata_q      <= cfg_data_i;
            step_q       <= '0;
            busy_o       <= 1'b1;
            vs_timeout_o <= 1'b0;
            st           <= SQ_HOLD;
          end
        end
        SQ_HOLD: begin
          if (timing_ok_i) st <= SQ_SEND;
        end
        SQ_SEND: begin
          if (tx_ready) begin
            tx_load <= 1'b1;
            st      <= SQ_XFER;
          end
        end
        SQ_XFER: begin
          if (tx_done) begin
            if (step_q == STEP_W'(STEP_W1)) begin
              vs_arm <= 1'b1;
              vs_tgt <= CNT_W'(WAIT_ONE);
              st     <= SQ_VWAIT;
            end else if (step_q == STEP_W'(STEP_W4)) begin
              vs_arm <= 1'b1;
              vs_tgt <= CNT_W'(WAIT_FOUR);
              st     <= SQ_VWAIT;
            end else if (step_q == STEP_W'(STEP_FINAL)) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              st     <= SQ_IDLE;
            end else begin
              step_q <= step_q + 1'b1;
              st     <= SQ_SEND;
            end
          end
        end
        SQ_VWAIT: begin
          if (vs_met) begin
            step_q <= step_q + 1'b1;
            st     <= SQ_SEND;
          end else if (vs_tmo) begin
            busy_o       <= 1'b0;
            vs_timeout_o <= 1'b1;
            st           <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  fe_ser_tx #(
    .CLK_DIV (CLK_DIV),
    .CS_GAP  (CS_GAP)
  ) tx_i (
    .clk     (clk),
    .rst     (rst),
    .load_i  (tx_load),
    .word_i  (cur_word),
    .ready_o (tx_ready),
    .done_o  (tx_done),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o),
    .cs_n_o  (cs_n_o)
  );

  fe_vsync_wait #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
  ) vw_i (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (vs_arm),
    .target_i  (vs_tgt),
    .vsync_i   (vsync_i),
    .met_o     (vs_met),
    .timeout_o (vs_tmo)
  );

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r4_quiet_until_stable: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_HOLD) |-> cs_n_o);

  a_r5_quiet_in_wait: assert property (@(posedge clk) disable iff (rst)
    (st == SQ_VWAIT) |-> cs_n_o);

  a_r9_step_bound: assert property (@(posedge clk) disable iff (rst)
    step_o <= 3'(STEP_FINAL));

  a_r10_flag_idle: assert property (@(posedge clk) disable iff (rst)
    vs_timeout_o |-> !busy_o);

endmodule

// File: tb/fe_init_seq_tb_top.sv
`timescale 1ns/1ps
module fe_init_seq_tb_top;

  localparam int CLK_DIV = 2;
  localparam int CS_GAP  = 2;
  localparam int W1      = 1;
  localparam int W4      = 4;
  localparam int TMO     = 2000;
  localparam int VS_PER  = 300;
  localparam int GAP_MIN = CS_GAP * 2 * CLK_DIV;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        timing_ok = 1'b0;
  logic        vsync = 1'b0;
  logic [7:0]  cfg_main = '0;
  logic [4:0]  cfg_aux = '0;
  logic [12:0] cfg_data = '0;
  logic        sclk, sdata, cs_n, busy, done, vs_timeout;
  logic [2:0]  step;

  logic vs_en   = 1'b0;
  logic mon_clr = 1'b0;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  fe_init_seq #(
    .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .WAIT_ONE(W1), .WAIT_FOUR(W4), .TIMEOUT_CYC(TMO)
  ) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .timing_ok_i(timing_ok), .vsync_i(vsync),
    .cfg_main_i(cfg_main), .cfg_aux_i(cfg_aux), .cfg_data_i(cfg_data),
    .sclk_o(sclk), .sdata_o(sdata), .cs_n_o(cs_n), .busy_o(busy), .done_o(done),
    .step_o(step), .vs_timeout_o(vs_timeout)
  );

  // Vertical-sync generator
  initial begin
    int tick = 0;
    forever begin
      @(posedge clk); #1;
      if (vs_en) begin
        tick  = (tick == VS_PER - 1) ? 0 : tick + 1;
        vsync = (tick == 0);
      end else begin
        vsync = 1'b0;
      end
    end
  end

  // Serial decoder / monitor
  int          nw;
  logic [15:0] words [0:15];
  int          nbits [0:15];
  int          gap_vs [0:15];
  int          gap_hi [0:15];
  int          step_at [0:15];
  int          ndone, glitch, done_busy;
  logic [15:0] sh;
  int          bc, vs_since, hi_run;
  logic        p_sclk, p_cs, p_vs, p_sd;

  always @(negedge clk) begin
    if (mon_clr) begin
      nw = 0; ndone = 0; glitch = 0; done_busy = 0;
      sh = '0; bc = 0; vs_since = 0; hi_run = 0;
    end else begin
      if (vsync && !p_vs) vs_since++;
      if (!p_cs && cs_n) begin
        if (nw < 16) begin words[nw] = sh; nbits[nw] = bc; end
        nw++;
        vs_since = 0;
        hi_run = 0;
      end
      if (cs_n) hi_run++;
      if (p_cs && !cs_n) begin
        if (nw < 16) begin gap_vs[nw] = vs_since; gap_hi[nw] = hi_run; step_at[nw] = int'(step); end
        bc = 0; sh = '0;
      end
      if (!cs_n && sclk && !p_sclk) begin sh = {sh[14:0], sdata}; bc++; end
      if (!cs_n && sclk && p_sclk && (sdata != p_sd)) glitch++;
      if (cs_n && sclk) glitch++;
      if (done) begin ndone++; if (busy) done_busy++; end
    end
    p_sclk = sclk; p_cs = cs_n; p_vs = vsync; p_sd = sdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int k, input logic [7:0] a, input logic [4:0] b, input logic [12:0] c);
    case (k)
      0: return 16'h0001;
      1: return 16'h2001;
      2: return {6'b001000, a, 2'b01};
      3: return {9'b111010000, b, 2'b10};
      4: return {6'b011000, a, 2'b01};
      5: return {6'b001000, a, 2'b01};
      default: return {1'b0, c, 2'b00};
    endcase
  endfunction

  task automatic clear_mon();
    @(posedge clk); #1 mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic wait_idle(input int limit);
    for (int i = 0; i < limit && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_series(input string tag, input logic [7:0] a, input logic [4:0] b, input logic [12:0] c);
    check(nw == 7, {tag, " R3 word count"}, nw, 7);
    for (int k = 0; k < 7; k++) begin
      check(words[k] == exp_word(k, a, b, c), {tag, " R3 word value"}, words[k], exp_word(k, a, b, c));
      check(nbits[k] == 16, {tag, " R2 bits per word"}, nbits[k], 16);
      check(step_at[k] == k, {tag, " R9 step index"}, step_at[k], k);
      if (k > 0) check(gap_hi[k] >= GAP_MIN, {tag, " R6 cs gap"}, gap_hi[k], GAP_MIN);
    end
    check(gap_vs[4] >= W1, {tag, " R5 one-period wait"}, gap_vs[4], W1);
    check(gap_vs[5] >= W4, {tag, " R5 four-period wait"}, gap_vs[5], W4);
    check(glitch == 0, {tag, " R2 data stable while clock high"}, glitch, 0);
    check(ndone == 1, {tag, " R7 single done pulse"}, ndone, 1);
    check(done_busy == 0, {tag, " R7 busy low with done"}, done_busy, 0);
    check(vs_timeout == 1'b0, {tag, " R10 no timeout"}, vs_timeout, 0);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && sdata == 1'b0, "R1 serial idle", {cs_n, sclk, sdata}, 3'b100);
    check(busy == 1'b0 && done == 1'b0 && vs_timeout == 1'b0, "R1 flags low", {busy, done, vs_timeout}, 0);
    check(step == 3'd0, "R1 step zero", step, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    check(cs_n == 1'b1 && busy == 1'b0, "R1 state after release", {cs_n, busy}, 2'b10);
  endtask

  task automatic test_full(input logic [7:0] a, input logic [4:0] b, input logic [12:0] c);
    timing_ok = 1'b1; vs_en = 1'b1;
    cfg_main = a; cfg_aux = b; cfg_data = c;
    clear_mon();
    pulse_start();
    check(busy == 1'b1, "R7 busy after start", busy, 1);
    wait_idle(20000);
    check_series("full", a, b, c);
  endtask

  task automatic test_hold_off();
    timing_ok = 1'b0; vs_en = 1'b1;
    cfg_main = 8'h3C; cfg_aux = 5'h11; cfg_data = 13'h0F0F;
    clear_mon();
    pulse_start();
    repeat (300) @(negedge clk);
    check(busy == 1'b1, "R4 busy during hold-off", busy, 1);
    check(nw == 0 && cs_n == 1'b1, "R4 no write before stable", nw, 0);
    @(posedge clk); #1 timing_ok = 1'b1;
    wait_idle(20000);
    check_series("holdoff R4", 8'h3C, 5'h11, 13'h0F0F);
  endtask

  task automatic test_ignore_start();
    timing_ok = 1'b1; vs_en = 1'b1;
    cfg_main = 8'h81; cfg_aux = 5'h06; cfg_data = 13'h1234;
    clear_mon();
    pulse_start();
    repeat (150) @(negedge clk);
    cfg_main = 8'h7E; cfg_aux = 5'h19; cfg_data = 13'h0ABC;
    pulse_start();
    repeat (700) @(negedge clk);
    pulse_start();
    wait_idle(20000);
    check_series("restart R8 R11", 8'h81, 5'h06, 13'h1234);
  endtask

  task automatic test_timeout();
    timing_ok = 1'b1; vs_en = 1'b0;
    cfg_main = 8'h55; cfg_aux = 5'h0A; cfg_data = 13'h1555;
    clear_mon();
    pulse_start();
    wait_idle(TMO * 3 + 2000);
    check(vs_timeout == 1'b1, "R10 timeout flag", vs_timeout, 1);
    check(busy == 1'b0, "R10 busy dropped", busy, 0);
    check(nw == 4, "R10 writes stop at wait", nw, 4);
    check(ndone == 0, "R10 no done pulse", ndone, 0);
    repeat (200) @(negedge clk);
    check(nw == 4 && cs_n == 1'b1, "R10 stays quiet", nw, 4);
    vs_en = 1'b1;
    clear_mon();
    pulse_start();
    @(negedge clk);
    check(vs_timeout == 1'b0, "R10 flag cleared by start", vs_timeout, 0);
    wait_idle(20000);
    check_series("recover R10", 8'h55, 5'h0A, 13'h1555);
  endtask

  bit finished = 1'b0;

  initial begin
    test_reset();
    test_full(8'hFF, 5'h1F, 13'h1FFF);
    test_full(8'hA5, 5'h15, 13'h0AAA);
    test_hold_off();
    test_ignore_start();
    test_timeout();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule